// File: doc/BRIEF.md
# Floating-Point Status and Control Register Unit

This block holds the 32-bit status and control word of a floating-point unit. Software reads it and overwrites it through a plain register port: a write-enable, a write-data bus and a read-data bus that always shows the current value. The arithmetic datapath updates the word through side-band inputs. These are a compare result that loads the four condition flags, six per-operation exception pulses and a saturation pulse. The exception pulses and the saturation pulse set sticky flags, which stay set until software writes them back to zero.

The control fields are exported as dedicated outputs, so the datapath never decodes the word itself. These are the rounding mode, flush-to-zero, default-NaN, and the short-vector length and stride. When an exception pulse arrives while its enable bit is set, the block raises a one-cycle trap request toward the trap logic. Reserved bit groups are held at zero at all times.

Top module: `fp_status_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the register becomes 0x00000000 and `trap_req` goes low.
- R2: A write (`sw_we`=1) replaces every non-reserved bit with `sw_wdata`, and the new value is visible on `sw_rdata` after that edge. Writing 0 clears every sticky flag.
- R3: Reserved bits 26, 19, 14, 13, 6 and 5 always read zero, even after a write of all ones (0xFFFFFFFF reads back as 0xFBF79F9F).
- R4: With `cmp_valid`=1, bits 31..28 (N,Z,C,V) are replaced as a group and every other bit is left unchanged. The `cmp_kind` encodings are 00 less-than → 1000, 01 equal → 0110, 10 greater-than → 0010 and 11 unordered → 0011.
- R5: `exc_pulse` bit i sets a sticky cumulative flag. Bits 0..5 (invalid, divide-by-zero, overflow, underflow, inexact, input-subnormal) map to register bits 0, 1, 2, 3, 4 and 7. The flag stays set until a write clears it.
- R6: `sat_pulse` sets the sticky saturation flag at bit 27.
- R7: When a write and hardware updates happen in the same cycle, the exception and saturation sets are ORed onto the written value, and a compare overrides the written bits 31..28.
- R8: `trap_req` is high for exactly the one cycle after an edge at which some `exc_pulse[i]` was high while its enable bit was 1. The enable bits are 8, 9, 10, 11, 12 and 15 for exception bits 0..5, taken from the register value held before that edge. The cumulative flag is set whether or not the exception is enabled.
- R9: The exported controls follow the register: `round_mode`=bits 23:22 (00 nearest, 01 toward +inf, 10 toward −inf, 11 toward zero), `default_nan`=bit 25, `flush_zero`=bit 24, `vec_len`=bits 18:16 and `vec_stride`=bits 21:20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current register value |
| cmp_valid | input | 1 | Compare result present this cycle |
| cmp_kind | input | 2 | Compare outcome: 00 lt, 01 eq, 10 gt, 11 unordered |
| exc_pulse | input | 6 | Exception pulses (invalid, div0, overflow, underflow, inexact, input-subnormal) |
| sat_pulse | input | 1 | Saturation occurred |
| round_mode | output | 2 | Rounding mode control |
| flush_zero | output | 1 | Flush-to-zero enable |
| default_nan | output | 1 | Default-NaN enable |
| vec_len | output | 3 | Short-vector length field |
| vec_stride | output | 2 | Short-vector stride field |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The hardest cases to reach are collisions at a single edge. In one, a software write, a compare and exception pulses land together, so the sticky sets, the compare override and the written value must all merge. In another, the write changes the very enable bits that the simultaneous exception's trap decision depends on. The stimulus drives these collisions directly from the ports. It first parks the register with chosen enables and then issues the write together with the pulses. This shows that the trap follows the enables held before the edge, while the flags carry both the written data and the new sets.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    localparam int REG_W   = 32;
    localparam int NUM_EXC = 6;

    // Field positions the datapath relies on
    localparam int NZCV_LSB   = 28;
    localparam int QC_BIT     = 27;
    localparam int DN_BIT     = 25;
    localparam int FZ_BIT     = 24;
    localparam int RM_LSB     = 22;
    localparam int STRIDE_LSB = 20;
    localparam int LEN_LSB    = 16;
    localparam int EN_OFFSET  = 8;

    localparam logic [REG_W-1:0] RSVD_MASK = 32'h0408_6060;
    localparam logic [REG_W-1:0] WR_MASK   = ~RSVD_MASK;

    typedef enum logic [1:0] {
        CMP_LT = 2'b00,
        CMP_EQ = 2'b01,
        CMP_GT = 2'b10,
        CMP_UN = 2'b11
    } cmp_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef struct packed {
        logic [1:0] rmode;
        logic       fz;
        logic       dn;
        logic [2:0] len;
        logic [1:0] stride;
    } ctrl_view_t;

    // Register bit holding the cumulative flag of exception index i
    function automatic int flag_pos(input int i);
        return (i < 5) ? i : 7;
    endfunction

    function automatic int enable_pos(input int i);
        return flag_pos(i) + EN_OFFSET;
    endfunction

    function automatic nzcv_t map_compare(input cmp_kind_e k);
        nzcv_t f;
        f = '0;
        unique case (k)
            CMP_LT: f.n = 1'b1;
            CMP_EQ: begin f.z = 1'b1; f.c = 1'b1; end
            CMP_GT: f.c = 1'b1;
            CMP_UN: begin f.c = 1'b1; f.v = 1'b1; end
            default: f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/fpsr_cmp_map.sv
module fpsr_cmp_map
    import fpsr_pkg::*;
(
    input  logic       cmp_valid,
    input  logic [1:0] cmp_kind,
    output logic       nzcv_load,
    output nzcv_t      nzcv_new
);
    always_comb begin
        nzcv_load = cmp_valid;
        nzcv_new  = map_compare(cmp_kind_e'(cmp_kind));
    end
endmodule

// File: rtl/fpsr_exc_unit.sv
module fpsr_exc_unit
    import fpsr_pkg::*;
#(
    parameter int N_EXC = NUM_EXC,
    parameter int W     = REG_W
) (
    input  logic [N_EXC-1:0] exc_pulse,
    input  logic [W-1:0]     reg_q,
    output logic [W-1:0]     set_mask,
    output logic             trap_hit
);
    logic [N_EXC-1:0] armed;
    logic [W-1:0]     bit_sets [N_EXC];

    for (genvar i = 0; i < N_EXC; i++) begin : g_exc
        localparam int FP = flag_pos(i);
        localparam int EP = enable_pos(i);
        always_comb begin
            bit_sets[i]     = '0;
            bit_sets[i][FP] = exc_pulse[i];
            armed[i]        = exc_pulse[i] & reg_q[EP];
        end
    end

    always_comb begin
        set_mask = '0;
        for (int i = 0; i < N_EXC; i++) begin
            set_mask = set_mask | bit_sets[i];
        end
        trap_hit = |armed;
    end
endmodule

// File: rtl/fpsr_ctrl_view.sv
module fpsr_ctrl_view
    import fpsr_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] reg_q,
    output ctrl_view_t   view
);
    always_comb begin
        view.rmode  = reg_q[RM_LSB +: 2];
        view.fz     = reg_q[FZ_BIT];
        view.dn     = reg_q[DN_BIT];
        view.len    = reg_q[LEN_LSB +: 3];
        view.stride = reg_q[STRIDE_LSB +: 2];
    end
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
    import fpsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_we,
    input  logic [31:0] sw_wdata,
    output logic [31:0] sw_rdata,
    input  logic        cmp_valid,
    input  logic [1:0]  cmp_kind,
    input  logic [5:0]  exc_pulse,
    input  logic        sat_pulse,
    output logic [1:0]  round_mode,
    output logic        flush_zero,
    output logic        default_nan,
    output logic [2:0]  vec_len,
    output logic [1:0]  vec_stride,
    output logic        trap_req
);
    logic [REG_W-1:0] reg_q;
    logic [REG_W-1:0] reg_d;
    logic [REG_W-1:0] exc_set;
    logic             trap_hit;
    logic             nzcv_load;
    nzcv_t            nzcv_new;
    ctrl_view_t       view;

    fpsr_cmp_map u_cmp (
        .cmp_valid (cmp_valid),
        .cmp_kind  (cmp_kind),
        .nzcv_load (nzcv_load),
        .nzcv_new  (nzcv_new)
    );

    fpsr_exc_unit #(.N_EXC(NUM_EXC), .W(REG_W)) u_exc (
        .exc_pulse (exc_pulse),
        .reg_q     (reg_q),
        .set_mask  (exc_set),
        .trap_hit  (trap_hit)
    );

    fpsr_ctrl_view #(.W(REG_W)) u_view (
        .reg_q (reg_q),
        .view  (view)
    );

    // Software value first, compare override next, sticky sets last
    always_comb begin
        reg_d = sw_we ? (sw_wdata & WR_MASK) : reg_q;
        if (nzcv_load) begin
            reg_d[NZCV_LSB +: 4] = nzcv_new;
        end
        reg_d[QC_BIT] = reg_d[QC_BIT] | sat_pulse;
        reg_d = (reg_d | exc_set) & WR_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q    <= '0;
            trap_req <= 1'b0;
        end else begin
            reg_q    <= reg_d;
            trap_req <= trap_hit;
        end
    end

    always_comb begin
        sw_rdata    = reg_q;
        round_mode  = view.rmode;
        flush_zero  = view.fz;
        default_nan = view.dn;
        vec_len     = view.len;
        vec_stride  = view.stride;
    end
endmodule

// File: rtl/fpsr_checker.sv
module fpsr_checker (
    input logic        clk,
    input logic        rst,
    input logic        sw_we,
    input logic [31:0] sw_rdata,
    input logic        cmp_valid,
    input logic [1:0]  cmp_kind,
    input logic [5:0]  exc_pulse,
    input logic        sat_pulse,
    input logic [1:0]  round_mode,
    input logic        flush_zero,
    input logic        default_nan,
    input logic [2:0]  vec_len,
    input logic [1:0]  vec_stride,
    input logic        trap_req
);
    logic [5:0] en_bits;
    logic [5:0] flag_bits;
    always_comb begin
        en_bits   = {sw_rdata[15], sw_rdata[12:8]};
        flag_bits = {sw_rdata[7], sw_rdata[4:0]};
    end

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (sw_rdata == 32'h0 && !trap_req));

    // R3
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (sw_rdata & 32'h0408_6060) == 32'h0);

    // R4
    a_r4_cmp_lt: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_kind == 2'b00) |=> sw_rdata[31:28] == 4'b1000);
    a_r4_cmp_eq: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_kind == 2'b01) |=> sw_rdata[31:28] == 4'b0110);
    a_r4_cmp_gt: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_kind == 2'b10) |=> sw_rdata[31:28] == 4'b0010);
    a_r4_cmp_un: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_kind == 2'b11) |=> sw_rdata[31:28] == 4'b0011);

    // R5 / R7: a pulse always lands, even under a write
    a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
        (exc_pulse != 6'b0) |=> ((flag_bits & $past(exc_pulse)) == $past(exc_pulse)));

    // R5: sticky without a write
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (!sw_we && flag_bits != 6'b0) |=> ((flag_bits & $past(flag_bits)) == $past(flag_bits)));

    // R6
    a_r6_sat_set: assert property (@(posedge clk) disable iff (rst)
        sat_pulse |=> sw_rdata[27]);

    // R8
    a_r8_trap_raise: assert property (@(posedge clk) disable iff (rst)
        ((exc_pulse & en_bits) != 6'b0) |=> trap_req);
    a_r8_trap_cause: assert property (@(posedge clk) disable iff (rst)
        ((exc_pulse & en_bits) == 6'b0) |=> !trap_req);

    // R9
    a_r9_exports: assert property (@(posedge clk) disable iff (rst)
        round_mode == sw_rdata[23:22] && default_nan == sw_rdata[25] &&
        flush_zero == sw_rdata[24] && vec_len == sw_rdata[18:16] &&
        vec_stride == sw_rdata[21:20]);
endmodule

bind fp_status_ctrl fpsr_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .sw_we       (sw_we),
    .sw_rdata    (sw_rdata),
    .cmp_valid   (cmp_valid),
    .cmp_kind    (cmp_kind),
    .exc_pulse   (exc_pulse),
    .sat_pulse   (sat_pulse),
    .round_mode  (round_mode),
    .flush_zero  (flush_zero),
    .default_nan (default_nan),
    .vec_len     (vec_len),
    .vec_stride  (vec_stride),
    .trap_req    (trap_req)
);

// File: tb/sim_fp_status_ctrl.sv
`timescale 1ns/1ps
module sim_fp_status_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_kind = '0;
    logic [5:0]  exc_pulse = '0;
    logic        sat_pulse = 1'b0;
    logic [1:0]  round_mode;
    logic        flush_zero, default_nan, trap_req;
    logic [2:0]  vec_len;
    logic [1:0]  vec_stride;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic [31:0] m_reg  = '0;
    logic        m_trap = 1'b0;
    int fpos [6] = '{0, 1, 2, 3, 4, 7};
    int epos [6] = '{8, 9, 10, 11, 12, 15};

    always #2.5 clk = ~clk;

    fp_status_ctrl u0 (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .cmp_valid(cmp_valid), .cmp_kind(cmp_kind),
        .exc_pulse(exc_pulse), .sat_pulse(sat_pulse), .round_mode(round_mode),
        .flush_zero(flush_zero), .default_nan(default_nan), .vec_len(vec_len),
        .vec_stride(vec_stride), .trap_req(trap_req)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle();
        sw_we = 1'b0; sw_wdata = '0; cmp_valid = 1'b0; cmp_kind = '0;
        exc_pulse = '0; sat_pulse = 1'b0;
    endtask

    // One clock: model advances from the inputs at the edge, compare at negedge
    task automatic step(string tag);
        logic [31:0] nxt;
        logic        tn;
        @(posedge clk);
        nxt = sw_we ? (sw_wdata & ~32'h0408_6060) : m_reg;
        if (cmp_valid) begin
            case (cmp_kind)
                2'b00: nxt[31:28] = 4'b1000;
                2'b01: nxt[31:28] = 4'b0110;
                2'b10: nxt[31:28] = 4'b0010;
                default: nxt[31:28] = 4'b0011;
            endcase
        end
        if (sat_pulse) nxt[27] = 1'b1;
        tn = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (exc_pulse[i]) begin
                nxt[fpos[i]] = 1'b1;
                if (m_reg[epos[i]]) tn = 1'b1;
            end
        end
        if (rst) begin nxt = '0; tn = 1'b0; end
        m_reg  = nxt;
        m_trap = tn;
        @(negedge clk);
        check(tag, sw_rdata, m_reg);
        check({tag, " trap R8"}, {31'b0, trap_req}, {31'b0, m_trap});
        check("R9 exports", {22'b0, round_mode, default_nan, flush_zero, vec_len, vec_stride},
              {22'b0, m_reg[23:22], m_reg[25], m_reg[24], m_reg[18:16], m_reg[21:20]});
    endtask

    task automatic wr(logic [31:0] v, string tag);
        sw_we = 1'b1; sw_wdata = v;
        step(tag);
        idle();
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset with pulses held active
        exc_pulse = 6'h3F; sat_pulse = 1'b1; sw_we = 1'b1; sw_wdata = '1;
        step("R1");
        step("R1");
        check("R1 reset value", sw_rdata, 32'h0);
        idle();
        rst = 1'b0;
        step("R1");

        // R3: reserved bits
        wr(32'hFFFF_FFFF, "R3");
        check("R3 all-ones readback", sw_rdata, 32'hFBF7_9F9F);
        // R2: clear and patterns
        wr(32'h0, "R2");
        check("R2 cleared", sw_rdata, 32'h0);
        wr(32'hA5A5_A5A5, "R2");
        wr(32'h5A5A_5A5A, "R2");

        // R9: every rounding mode, with fz/dn/len/stride patterns
        for (int r = 0; r < 4; r++) begin
            wr({6'b0, r[0], r[1], r[1:0], r[1:0], 1'b0, 3'(r + 3), 16'h0}, "R9");
        end

        // R4: each compare kind, other fields kept
        wr(32'h0153_9F00, "R2");
        for (int k = 0; k < 4; k++) begin
            cmp_valid = 1'b1; cmp_kind = 2'(k);
            step("R4");
            idle();
        end
        check("R4 unordered NZCV", {28'b0, sw_rdata[31:28]}, 32'h3);

        // R5: exceptions with enables off, each index alone
        wr(32'h0, "R2");
        for (int i = 0; i < 6; i++) begin
            exc_pulse = 6'(1 << i);
            step("R5");
            idle();
            step("R5");
        end
        check("R5 all flags", sw_rdata, 32'h0000_009F);
        check("R8 no trap when disabled", {31'b0, trap_req}, 32'h0);
        wr(32'h0, "R5");

        // R6: saturation sticky
        sat_pulse = 1'b1; step("R6"); idle();
        step("R6"); step("R6");
        check("R6 saturation held", {31'b0, sw_rdata[27]}, 32'h1);

        // R8: enable each exception singly, pulse, watch one-cycle trap
        for (int i = 0; i < 6; i++) begin
            wr(32'(1) << epos[i], "R8");
            exc_pulse = 6'(1 << i);
            step("R8");
            idle();
            check("R8 trap pulse", {31'b0, trap_req}, 32'h1);
            step("R8");
            check("R8 trap drops", {31'b0, trap_req}, 32'h0);
            // a different, disabled exception raises no trap
            exc_pulse = 6'(1 << ((i + 1) % 6));
            step("R8");
            idle();
        end

        // R7: write plus compare plus pulses in one cycle
        wr(32'h0000_9F00, "R2");
        sw_we = 1'b1; sw_wdata = 32'hF000_0000; cmp_valid = 1'b1; cmp_kind = 2'b10;
        exc_pulse = 6'b100001; sat_pulse = 1'b1;
        step("R7");
        idle();
        check("R7 merged", sw_rdata, 32'h2800_0081);
        check("R7 trap from old enables", {31'b0, trap_req}, 32'h1);

        // R8 + R7: write enabling an exception in the same cycle -> no trap
        sw_we = 1'b1; sw_wdata = 32'h0000_0400; exc_pulse = 6'b000100;
        step("R8");
        idle();
        check("R8 new enable not used", {31'b0, trap_req}, 32'h0);
        // write disabling it while pulsing -> old enable traps
        sw_we = 1'b1; sw_wdata = 32'h0; exc_pulse = 6'b000100;
        step("R8");
        idle();
        check("R8 old enable used", {31'b0, trap_req}, 32'h1);
        step("R8");

        // R1: reset again mid-run
        rst = 1'b1; step("R1"); rst = 1'b0; step("R1");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule